// File: doc/BRIEF.md
# Watchdog Frequency-Recovery Controller

This block guards a programmable clock synthesizer against a frequency setting that hangs the system. Software arms a countdown measured in slow ticks (one tick stands for 250 ms, so the reset depth of 8 gives 2.0 s). If software does not cancel the countdown before it runs out, the block pulses an active-low system reset. It also sets a sticky timeout flag, drops direct M/N programming, and loads a known-good frequency code.

The block also picks the frequency code that drives the synthesizer. There are three sources: the select pins latched at power-on, a software code, or a stored safe code. The safe code is used only when a timeout reloads the software code. Register access is a simple single-cycle write port and a combinational read port with a 2-bit address.

Top module: `wdt_freq_recovery`

## Requirements
- R1: After reset, `freq_code` equals `hw_sel` and `mn_mode` is 0. `rst_out_n` is 1. Address 2 reads 8 and address 1 reads 0x02.
- R2: Address 0 holds the control register: bits [4:0] software code, bit 5 software-select enable, bit 6 safe-source select, bit 7 M/N enable. `freq_code` is bits [4:0] when bit 5 is 1, and `hw_sel` otherwise. `mn_mode` follows bit 7.
- R3: Arming takes two writes. First set bit 6 (count enable) of address 1, then write the depth to address 2 bits [6:0]. A depth write made while count enable is 0 starts nothing.
- R4: With depth D ≥ 1 the timeout happens on the D-th tick after arming; depth 0 times out on the first tick. While counting, address 2 reads the remaining count.
- R5: Address 1 bit 6 reads 1 while a countdown runs and 0 once it has expired.
- R6: Address 1 bit 7 is a read-only timeout flag. It is 0 after reset, becomes 1 at timeout, and is cleared by the next arming write. Writes to it have no effect.
- R7: `rst_out_n` goes low on the clock edge of the expiring tick. It stays low for exactly RST_CYCLES clock cycles (16 by default), then returns high.
- R8: At timeout the control register changes as follows: bit 7 is cleared, bit 5 is set, and bits [4:0] are loaded with the safe code (address 1 bits [4:0], reset value 00010) if control bit 6 is 1, or with `hw_sel` if it is 0. `freq_code` then equals that code.
- R9: Clearing count enable during a countdown stops it. No timeout follows, the flag stays 0 and `rst_out_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable marking one 250 ms step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| hw_sel | input | 5 | Power-on latched frequency select pins |
| rst_out_n | output | 1 | Active-low system reset pulse |
| freq_code | output | 5 | Active frequency table code |
| mn_mode | output | 1 | Direct M/N programming enable |

## Verification
The bench uses the default parameters: 7-bit depth, 5-bit codes, a reset depth of 8 and a 16-cycle reset pulse. Because the bench drives `tick` itself, a whole countdown takes only a few dozen clock cycles. This makes depths 0 and 1, mid-count readback of every remaining value, cancellation, and both reload sources reachable in many random rounds. Timing the full 16-cycle reset pulse edge by edge is also cheap.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  localparam int CODE_W  = 5;
  localparam int DEPTH_W = 7;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [DEPTH_W-1:0] depth_t;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_WDOG  = 2'd1,
    A_DEPTH = 2'd2,
    A_NONE  = 2'd3
  } reg_addr_e;

  // Normal selection between software code and latched pins.
  function automatic code_t pick_code(input logic sw_en, input code_t sw, input code_t hw);
    return sw_en ? sw : hw;
  endfunction

  // Code loaded on timeout.
  function automatic code_t reload_code(input logic safe_en, input code_t safe, input code_t hw);
    return safe_en ? safe : hw;
  endfunction

  // Last step of the countdown: remaining 1, or 0 when armed with depth 0.
  function automatic logic last_step(input depth_t remain);
    return remain <= depth_t'(1);
  endfunction
endpackage

// File: rtl/wdr_regs.sv
module wdr_regs
  import wdr_pkg::*;
#(
  parameter int DEPTH_RST = 8,
  parameter int SAFE_RST  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  input  code_t             hw_sel,
  output code_t             sw_code,
  output logic              sw_en,
  output logic              safe_en,
  output logic              mn_en,
  output code_t             safe_code,
  output logic              cnt_en,
  output depth_t            depth_cfg
);
  logic wr_ctrl, wr_wdog, wr_depth;
  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_wdog  = wr_en && (wr_addr == A_WDOG);
  assign wr_depth = wr_en && (wr_addr == A_DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_code <= '0;
      sw_en   <= 1'b0;
      safe_en <= 1'b0;
      mn_en   <= 1'b0;
    end else if (expire) begin
      sw_code <= reload_code(safe_en, safe_code, hw_sel);
      sw_en   <= 1'b1;
      mn_en   <= 1'b0;
    end else if (wr_ctrl) begin
      sw_code <= wr_data[CODE_W-1:0];
      sw_en   <= wr_data[5];
      safe_en <= wr_data[6];
      mn_en   <= wr_data[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      safe_code <= code_t'(SAFE_RST);
      cnt_en    <= 1'b0;
    end else if (wr_wdog) begin
      safe_code <= wr_data[CODE_W-1:0];
      cnt_en    <= wr_data[6];
    end else if (expire) begin
      cnt_en    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        depth_cfg <= depth_t'(DEPTH_RST);
    else if (wr_depth) depth_cfg <= wr_data[DEPTH_W-1:0];
  end
endmodule

// File: rtl/wdr_count.sv
module wdr_count
  import wdr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   arm,
  input  depth_t load_val,
  input  logic   cnt_en,
  output logic   counting,
  output depth_t remain,
  output logic   expire,
  output logic   flag
);
  assign expire = counting && cnt_en && tick && !arm && last_step(remain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      counting <= 1'b0;
      remain   <= '0;
      flag     <= 1'b0;
    end else if (arm) begin
      counting <= 1'b1;
      remain   <= load_val;
      flag     <= 1'b0;
    end else if (counting && !cnt_en) begin
      counting <= 1'b0;
    end else if (expire) begin
      counting <= 1'b0;
      remain   <= '0;
      flag     <= 1'b1;
    end else if (counting && tick) begin
      remain   <= remain - depth_t'(1);
    end
  end
endmodule

// File: rtl/wdr_rst_pulse.sv
module wdr_rst_pulse #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_out_n
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (fire)        left <= CW'(CYCLES);
    else if (left != '0)  left <= left - CW'(1);
  end

  assign rst_out_n = (left == '0);
endmodule

// File: rtl/wdt_freq_recovery.sv
module wdt_freq_recovery
  import wdr_pkg::*;
#(
  parameter int DEPTH_RST  = 8,
  parameter int SAFE_RST   = 2,
  parameter int RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic [4:0]  hw_sel,
  output logic        rst_out_n,
  output logic [4:0]  freq_code,
  output logic        mn_mode
);
  code_t  sw_code, safe_code;
  logic   sw_en, safe_en, mn_en, cnt_en;
  depth_t depth_cfg, remain;
  logic   counting, expire, flag, arm;

  assign arm = wr_en && (wr_addr == A_DEPTH) && cnt_en;

  wdr_regs #(.DEPTH_RST(DEPTH_RST), .SAFE_RST(SAFE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .expire(expire), .hw_sel(hw_sel), .sw_code(sw_code), .sw_en(sw_en),
    .safe_en(safe_en), .mn_en(mn_en), .safe_code(safe_code), .cnt_en(cnt_en),
    .depth_cfg(depth_cfg)
  );

  wdr_count u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .load_val(wr_data[DEPTH_W-1:0]),
    .cnt_en(cnt_en), .counting(counting), .remain(remain), .expire(expire), .flag(flag)
  );

  wdr_rst_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire), .rst_out_n(rst_out_n)
  );

  assign freq_code = pick_code(sw_en, sw_code, hw_sel);
  assign mn_mode   = mn_en;

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      A_CTRL:  rd_data = {mn_en, safe_en, sw_en, sw_code};
      A_WDOG:  rd_data = {flag, cnt_en, 1'b0, safe_code};
      A_DEPTH: rd_data = {1'b0, counting ? remain : depth_cfg};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdr_chk.sv
module wdr_chk
  import wdr_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   arm,
  input logic   expire,
  input logic   counting,
  input depth_t remain,
  input logic   flag,
  input logic   rst_out_n,
  input logic   mn_mode,
  input code_t  freq_code,
  input logic   safe_en,
  input code_t  safe_code,
  input code_t  hw_sel
);
  a_r7_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !rst_out_n);
  a_r7_low_only_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out_n && $past(rst_out_n)) |-> $past(expire));
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  a_r6_flag_rises_by_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !$past(flag)) |-> $past(expire));
  a_r6_arm_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!flag && counting));
  a_r8_mn_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !mn_mode);
  a_r8_code_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> freq_code == $past(safe_en ? safe_code : hw_sel));
  a_r4_no_increase: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && $past(counting) && !$past(arm)) |-> remain <= $past(remain));
endmodule

bind wdt_freq_recovery wdr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .expire(expire), .counting(counting),
  .remain(remain), .flag(flag), .rst_out_n(rst_out_n), .mn_mode(mn_mode),
  .freq_code(freq_code), .safe_en(safe_en), .safe_code(safe_code), .hw_sel(hw_sel)
);

// File: tb/wdt_freq_recovery_tb.sv
module wdt_freq_recovery_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, tick, wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [4:0] hw_sel, freq_code;
  logic rst_out_n, mn_mode;
  int checks = 0, fails = 0;

  wdt_freq_recovery u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .hw_sel(hw_sel),
    .rst_out_n(rst_out_n), .freq_code(freq_code), .mn_mode(mn_mode)
  );

  function automatic logic [4:0] exp_sel(logic en, logic [4:0] sw, logic [4:0] hw);
    if (en) return sw;
    return hw;
  endfunction

  function automatic int ticks_needed(int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; hw_sel = 5'h15;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(freq_code == 5'h15, "R1 code", freq_code, 5'h15);
    chk(mn_mode == 1'b0, "R1 mn", mn_mode, 0);
    chk(rst_out_n == 1'b1, "R1 rst_out", rst_out_n, 1);
    rd(2'd2, v); chk(v == 8'd8, "R1 depth", v, 8);
    rd(2'd1, v); chk(v == 8'h02, "R1 wdog", v, 8'h02);

    // R6 flag not writable
    wr(2'd1, 8'h82);
    rd(2'd1, v); chk(v[7] == 1'b0, "R6 flag write ignored", v[7], 0);

    // R2 selection
    wr(2'd0, 8'hAB);
    chk(freq_code == 5'h0B, "R2 sw code", freq_code, 5'h0B);
    chk(mn_mode == 1'b1, "R2 mn", mn_mode, 1);
    wr(2'd0, 8'h0B);
    chk(freq_code == hw_sel, "R2 hw code", freq_code, hw_sel);

    // R3 depth write without enable starts nothing
    wr(2'd1, 8'h02);
    wr(2'd2, 8'd3);
    repeat (6) do_tick();
    chk(rst_out_n == 1'b1, "R3 no reset", rst_out_n, 1);
    rd(2'd1, v); chk(v[7] == 1'b0, "R3 no flag", v[7], 0);
    rd(2'd2, v); chk(v == 8'd3, "R3 depth held", v, 3);

    // R9 cancel mid count
    wr(2'd1, 8'h42);
    wr(2'd2, 8'd5);
    do_tick(); do_tick();
    rd(2'd2, v); chk(v == 8'd3, "R4 remaining", v, 3);
    wr(2'd1, 8'h02);
    repeat (6) do_tick();
    chk(rst_out_n == 1'b1, "R9 no reset", rst_out_n, 1);
    rd(2'd1, v); chk(v[7:6] == 2'b00, "R9 flag/enable", v[7:6], 0);

    // R4 depth zero expires on first tick
    wr(2'd1, 8'h42);
    wr(2'd2, 8'd0);
    do_tick();
    chk(rst_out_n == 1'b0, "R4 depth0 timeout", rst_out_n, 0);
    rd(2'd1, v); chk(v[7] == 1'b1, "R4 depth0 flag", v[7], 1);
    repeat (20) @(negedge clk);

    // Random rounds
    for (int r = 0; r < 30; r++) begin
      int d, n;
      logic safe_en, sw_en;
      logic [4:0] safe, sw, hw, e;
      d = $urandom_range(1, 12);
      safe_en = 1'($urandom_range(0, 1));
      sw_en = 1'($urandom_range(0, 1));
      safe = 5'($urandom_range(0, 31));
      sw = 5'($urandom_range(0, 31));
      hw = 5'($urandom_range(0, 31));
      hw_sel = hw;
      wr(2'd0, {1'b1, safe_en, sw_en, sw});
      chk(freq_code == exp_sel(sw_en, sw, hw), "R2 random sel", freq_code, exp_sel(sw_en, sw, hw));
      wr(2'd1, {2'b01, 1'b0, safe});
      wr(2'd2, 8'(d));
      rd(2'd1, v);
      chk(v[7:6] == 2'b01, "R5 R6 counting flags", v[7:6], 1);
      n = ticks_needed(d);
      for (int k = 1; k < n; k++) begin
        do_tick();
        repeat ($urandom_range(0, 2)) @(negedge clk);
        rd(2'd2, v);
        chk(v == 8'(d - k) && rst_out_n, "R4 countdown", v, d - k);
      end
      do_tick();
      e = safe_en ? safe : hw;
      chk(rst_out_n == 1'b0, "R7 reset asserted", rst_out_n, 0);
      rd(2'd1, v);
      chk(v[7:6] == 2'b10, "R5 R6 after expiry", v[7:6], 2);
      chk(mn_mode == 1'b0, "R8 mn cleared", mn_mode, 0);
      chk(freq_code == e, "R8 reload code", freq_code, e);
      rd(2'd0, v);
      chk(v == {2'b0, safe_en, 1'b1, e}, "R8 ctrl reg", v, {2'b0, safe_en, 1'b1, e});
      repeat (15) @(negedge clk);
      chk(rst_out_n == 1'b0, "R7 still low", rst_out_n, 0);
      @(negedge clk);
      chk(rst_out_n == 1'b1, "R7 released", rst_out_n, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule